// File: doc/BRIEF.md
# LCD Common Scan Driver

This block drives the row (common) electrodes of a dot-matrix LCD panel. It contains two independent 50-stage scan shift registers. The left chain feeds outputs 1 to 50 and the right chain feeds outputs 51 to 100. A single direction select reverses both chains together. A scan bit enters at the port on the entry end of each chain and shifts one stage on every falling edge of the scan clock. The exit-end port carries the last stage, so several drivers can be chained for tall panels.

Each chain can also skip ten outputs at its entry end, which makes it a 40-stage chain. This is used for panels whose line count is not a multiple of 100. The left chain skips outputs 1 to 10 when scanning upward. The right chain skips outputs 91 to 100 when scanning downward.

Every register bit is combined with a frame-inversion bit and a display enable. The result is a 2-bit code that picks one of four bias levels for that row. Analog level shifting is done outside the block.

The scan ports are plain serial pins. There is no valid/ready handshake and no back-pressure. Each falling clock edge moves data unconditionally, and the upstream source has to present the next scan bit before every fall.

Top module: `lcd_common_driver`

## Requirements
- R1: All state changes on the falling edge of `scan_clk`. Output k (1..100) is driven from its own stage, and its code sits at `lvl_code[2k-1:2k-2]`.
- R2: With `dir_rev`=0, a bit on `pa_in` is loaded into output 1 at the first fall and moves up one output per fall. It shows on `pb_out` after exactly 50 falls. The right chain works the same way from `pc_in` (output 51) to `pd_out`.
- R3: With `dir_rev`=1, a bit on `pb_in` is loaded into output 50 and moves down one output per fall. It shows on `pa_out` after exactly 50 falls. The right chain works the same way from `pd_in` (output 100) to `pc_out`.
- R4: With `skip_left`=1 and `dir_rev`=0, a bit on `pa_in` is loaded straight into output 11 and shows on `pb_out` after 40 falls. The stages of outputs 1–10 are cleared at each fall, so those outputs show the data-0 level.
- R5: With `skip_right`=1 and `dir_rev`=1, a bit on `pd_in` is loaded straight into output 90 and shows on `pc_out` after 40 falls. The stages of outputs 91–100 are cleared at each fall.
- R6: `skip_left` has no effect while `dir_rev`=1, and `skip_right` has no effect while `dir_rev`=0. In both cases the affected chain keeps its full 50-fall latency.
- R7: With `disp_on`=1, the codes are as follows (V1=00, V2=01, V5=10, VEE=11):
  - frame 0, data 0 gives 01
  - frame 0, data 1 gives 11
  - frame 1, data 0 gives 10
  - frame 1, data 1 gives 00
- R8: With `disp_on`=0, every output code is 00 (V1), whatever the register data.
- R9: The enables `pb_oe` and `pd_oe` are 1 exactly when `dir_rev`=0. The enables `pa_oe` and `pc_oe` are 1 exactly when `dir_rev`=1.
- R10: `rst` high at a falling edge clears all 100 stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| scan_clk | input | 1 | Scan clock; shifting happens on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| dir_rev | input | 1 | 0: scan upward (1→50, 51→100); 1: scan downward |
| skip_left | input | 1 | Skip outputs 1–10 when scanning upward |
| skip_right | input | 1 | Skip outputs 91–100 when scanning downward |
| frame_inv | input | 1 | Frame inversion bit |
| disp_on | input | 1 | 0 forces every output to V1 |
| pa_in | input | 1 | Scan port at output 1, input side |
| pa_out | output | 1 | Scan port at output 1, driven value |
| pa_oe | output | 1 | Scan port at output 1, drive enable |
| pb_in | input | 1 | Scan port at output 50, input side |
| pb_out | output | 1 | Scan port at output 50, driven value |
| pb_oe | output | 1 | Scan port at output 50, drive enable |
| pc_in | input | 1 | Scan port at output 51, input side |
| pc_out | output | 1 | Scan port at output 51, driven value |
| pc_oe | output | 1 | Scan port at output 51, drive enable |
| pd_in | input | 1 | Scan port at output 100, input side |
| pd_out | output | 1 | Scan port at output 100, driven value |
| pd_oe | output | 1 | Scan port at output 100, drive enable |
| lvl_code | output | 200 | Two-bit level code per output, output k at bits 2k-1:2k-2 |

## Verification
A single 1 is walked through each chain in each direction. Checks at the entry output, at mid-chain and at the fall before and after the exit fall separate a wrong direction, a wrong output mapping and a latency that is off by one.

An all-ones fill followed by turning on a skip mode shows whether the skipped stages are really cleared rather than just passed over. It also shows that the new bit lands at output 11 or 90. Each skip select is also applied in the opposite direction to confirm it is ignored there.

One stage holding 1 next to one holding 0 is swept through all frame and display-enable combinations. This covers the full level table.

// File: rtl/lcdcom_pkg.sv
package lcdcom_pkg;

  typedef enum logic [1:0] {
    LVL_V1  = 2'b00,
    LVL_V2  = 2'b01,
    LVL_V5  = 2'b10,
    LVL_VEE = 2'b11
  } drive_lvl_e;

  // Select level from display enable, frame phase and row select bit
  function automatic drive_lvl_e pick_level(input logic on, input logic frame,
                                            input logic row_sel);
    drive_lvl_e lvl;
    if (!on)
      lvl = LVL_V1;
    else if (!frame)
      lvl = row_sel ? LVL_VEE : LVL_V2;
    else
      lvl = row_sel ? LVL_V1 : LVL_V5;
    return lvl;
  endfunction

endpackage

// File: rtl/com_scan_chain.sv
module com_scan_chain #(
  parameter int STAGES    = 50,
  parameter int SKIP      = 10,
  parameter bit ENTRY_LOW = 1'b1   // 1: skip applies upward at low end; 0: downward at high end
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rev,
  input  logic              skip,
  input  logic              lo_in,
  input  logic              hi_in,
  output logic [STAGES-1:0] stg,
  output logic              lo_out,
  output logic              hi_out
);

  localparam logic [STAGES-1:0] ONES     = '1;
  localparam logic [STAGES-1:0] CLR_MASK = ENTRY_LOW ? (ONES >> (STAGES - SKIP))
                                                     : (ONES << (STAGES - SKIP));
  localparam int LOAD_IDX = ENTRY_LOW ? SKIP : (STAGES - SKIP - 1);

  logic              skip_act;
  logic [STAGES-1:0] up_v, dn_v, nxt;

  assign skip_act = ENTRY_LOW ? (skip & ~rev) : (skip & rev);
  assign up_v     = {stg[STAGES-2:0], lo_in};
  assign dn_v     = {hi_in, stg[STAGES-1:1]};

  always_comb begin
    nxt = rev ? dn_v : up_v;
    if (skip_act) begin
      nxt           = nxt & ~CLR_MASK;
      nxt[LOAD_IDX] = ENTRY_LOW ? lo_in : hi_in;
    end
  end

  always_ff @(negedge clk) begin
    if (rst) stg <= '0;
    else     stg <= nxt;
  end

  assign lo_out = stg[0];
  assign hi_out = stg[STAGES-1];

  // R2: upward shift moves each stage one place up
  assert_up_shift_R2: assert property (@(negedge clk) disable iff (rst)
    (!rev && !skip_act) |=> (stg[STAGES-1:1] == $past(stg[STAGES-2:0])));

  // R3: downward shift moves each stage one place down
  assert_dn_shift_R3: assert property (@(negedge clk) disable iff (rst)
    (!rev && 1'b0) || (rev && !skip_act) |=> (stg[STAGES-2:0] == $past(stg[STAGES-1:1])));

  // R4 / R5: skipped stages hold zero after a fall in skip mode
  assert_skip_clear_R4: assert property (@(negedge clk) disable iff (rst)
    skip_act |=> ((stg & CLR_MASK) == '0));

  // R4 / R5: entry bit lands in the first unskipped stage
  assert_skip_load_R5: assert property (@(negedge clk) disable iff (rst)
    skip_act |=> (stg[LOAD_IDX] == (ENTRY_LOW ? $past(lo_in) : $past(hi_in))));

  // R10: reset clears every stage
  assert_reset_clear_R10: assert property (@(negedge clk)
    rst |=> (stg == '0));

endmodule

// File: rtl/com_level_map.sv
module com_level_map #(
  parameter int N = 100
) (
  input  logic           disp_on,
  input  logic           frame_inv,
  input  logic [N-1:0]   row_bits,
  output logic [2*N-1:0] codes
);
  import lcdcom_pkg::*;

  for (genvar g = 0; g < N; g++) begin : g_lvl
    assign codes[2*g +: 2] = pick_level(disp_on, frame_inv, row_bits[g]);
  end

  // R8: blanked display drives V1 everywhere
  always_comb begin
    if (disp_on === 1'b0)
      assert_blank_v1_R8: assert (codes == '0);
  end

endmodule

// File: rtl/lcd_common_driver.sv
module lcd_common_driver #(
  parameter int CHAIN_LEN = 50,
  parameter int SKIP_LEN  = 10
) (
  input  logic                   scan_clk,
  input  logic                   rst,
  input  logic                   dir_rev,
  input  logic                   skip_left,
  input  logic                   skip_right,
  input  logic                   frame_inv,
  input  logic                   disp_on,
  input  logic                   pa_in,
  output logic                   pa_out,
  output logic                   pa_oe,
  input  logic                   pb_in,
  output logic                   pb_out,
  output logic                   pb_oe,
  input  logic                   pc_in,
  output logic                   pc_out,
  output logic                   pc_oe,
  input  logic                   pd_in,
  output logic                   pd_out,
  output logic                   pd_oe,
  output logic [4*CHAIN_LEN-1:0] lvl_code
);

  localparam int TOTAL = 2 * CHAIN_LEN;

  logic [CHAIN_LEN-1:0] left_q, right_q;
  logic [TOTAL-1:0]     row_bits;

  com_scan_chain #(.STAGES(CHAIN_LEN), .SKIP(SKIP_LEN), .ENTRY_LOW(1'b1)) u_left (
    .clk(scan_clk), .rst(rst), .rev(dir_rev), .skip(skip_left),
    .lo_in(pa_in), .hi_in(pb_in), .stg(left_q),
    .lo_out(pa_out), .hi_out(pb_out)
  );

  com_scan_chain #(.STAGES(CHAIN_LEN), .SKIP(SKIP_LEN), .ENTRY_LOW(1'b0)) u_right (
    .clk(scan_clk), .rst(rst), .rev(dir_rev), .skip(skip_right),
    .lo_in(pc_in), .hi_in(pd_in), .stg(right_q),
    .lo_out(pc_out), .hi_out(pd_out)
  );

  assign row_bits = {right_q, left_q};

  com_level_map #(.N(TOTAL)) u_map (
    .disp_on(disp_on), .frame_inv(frame_inv),
    .row_bits(row_bits), .codes(lvl_code)
  );

  // Exit-end ports drive; entry-end ports listen
  assign pa_oe = dir_rev;
  assign pc_oe = dir_rev;
  assign pb_oe = ~dir_rev;
  assign pd_oe = ~dir_rev;

endmodule

// File: tb/tb_lcd_common_driver.sv
module tb_lcd_common_driver;

  logic scan_clk = 1'b0;
  logic rst = 1'b1, dir_rev = 1'b0, skip_left = 1'b0, skip_right = 1'b0;
  logic frame_inv = 1'b0, disp_on = 1'b1;
  logic pa_in = 1'b0, pb_in = 1'b0, pc_in = 1'b0, pd_in = 1'b0;
  logic pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe, pd_out, pd_oe;
  logic [199:0] lvl_code;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 scan_clk = ~scan_clk;

  lcd_common_driver dut (
    .scan_clk(scan_clk), .rst(rst), .dir_rev(dir_rev),
    .skip_left(skip_left), .skip_right(skip_right),
    .frame_inv(frame_inv), .disp_on(disp_on),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
    .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
    .lvl_code(lvl_code)
  );

  function automatic int code_of(int k);
    return int'(lvl_code[2*k-1 -: 2]);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_code(input int k, input int exp, input string req);
    check(code_of(k) == exp, $sformatf("%s out%0d", req, k), code_of(k), exp);
  endtask

  // One falling edge with given port inputs; returns mid-high phase
  task automatic tick(input logic a, input logic b, input logic c, input logic d);
    pa_in = a; pb_in = b; pc_in = c; pd_in = d;
    @(posedge scan_clk); #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(0, 0, 0, 0); tick(0, 0, 0, 0); rst = 1'b0;
  endtask

  task automatic t_reset_R10();
    frame_inv = 0; disp_on = 1;
    tick(1, 1, 1, 1); tick(1, 1, 1, 1);
    do_reset();
    for (int k = 1; k <= 100; k++) chk_code(k, 1, "R10 reset");
  endtask

  task automatic t_up_R2();
    dir_rev = 0; skip_left = 0; skip_right = 0; do_reset();
    tick(1, 0, 1, 0);
    chk_code(1, 3, "R2 R1 entry"); chk_code(51, 3, "R2 entry right");
    chk_code(2, 1, "R2 neighbour");
    for (int n = 2; n <= 50; n++) begin
      tick(0, 0, 0, 0);
      if (n == 25) begin
        chk_code(25, 3, "R2 mid"); chk_code(75, 3, "R2 mid right");
        chk_code(24, 1, "R2 trailing");
      end
      if (n == 49) begin
        check(pb_out == 0, "R2 pb early", pb_out, 0);
        check(pd_out == 0, "R2 pd early", pd_out, 0);
      end
      if (n == 50) begin
        check(pb_out == 1, "R2 pb exit", pb_out, 1);
        check(pd_out == 1, "R2 pd exit", pd_out, 1);
      end
    end
  endtask

  task automatic t_dn_R3();
    dir_rev = 1; skip_left = 0; skip_right = 0; do_reset();
    tick(0, 1, 0, 1);
    chk_code(50, 3, "R3 entry"); chk_code(100, 3, "R3 entry right");
    for (int n = 2; n <= 50; n++) begin
      tick(0, 0, 0, 0);
      if (n == 20) begin chk_code(31, 3, "R3 mid"); chk_code(81, 3, "R3 mid right"); end
      if (n == 49) begin
        check(pa_out == 0, "R3 pa early", pa_out, 0);
        check(pc_out == 0, "R3 pc early", pc_out, 0);
      end
      if (n == 50) begin
        check(pa_out == 1, "R3 pa exit", pa_out, 1);
        check(pc_out == 1, "R3 pc exit", pc_out, 1);
      end
    end
  endtask

  task automatic t_skip_left_R4();
    dir_rev = 0; skip_left = 0; skip_right = 0; do_reset();
    for (int n = 0; n < 50; n++) tick(1, 0, 0, 0);
    chk_code(1, 3, "R4 fill"); chk_code(10, 3, "R4 fill");
    skip_left = 1;
    tick(0, 0, 0, 0);
    for (int k = 1; k <= 10; k++) chk_code(k, 1, "R4 cleared");
    chk_code(11, 1, "R4 load zero"); chk_code(12, 3, "R4 shifted");
    do_reset();
    tick(1, 0, 1, 0);
    chk_code(11, 3, "R4 load"); chk_code(1, 1, "R4 skip out1"); chk_code(51, 3, "R4 right normal");
    for (int n = 2; n <= 50; n++) begin
      tick(0, 0, 0, 0);
      if (n == 39) check(pb_out == 0, "R4 pb early", pb_out, 0);
      if (n == 40) begin
        check(pb_out == 1, "R4 pb exit", pb_out, 1);
        check(pd_out == 0, "R4 right not early", pd_out, 0);
      end
      if (n == 50) check(pd_out == 1, "R4 right exit", pd_out, 1);
    end
    skip_left = 0;
  endtask

  task automatic t_skip_right_R5();
    dir_rev = 1; skip_left = 0; skip_right = 0; do_reset();
    for (int n = 0; n < 50; n++) tick(0, 0, 0, 1);
    skip_right = 1;
    tick(0, 0, 0, 0);
    for (int k = 91; k <= 100; k++) chk_code(k, 1, "R5 cleared");
    chk_code(90, 1, "R5 load zero"); chk_code(89, 3, "R5 shifted");
    do_reset();
    tick(0, 1, 0, 1);
    chk_code(90, 3, "R5 load"); chk_code(100, 1, "R5 skip out100"); chk_code(50, 3, "R5 left normal");
    for (int n = 2; n <= 50; n++) begin
      tick(0, 0, 0, 0);
      if (n == 39) check(pc_out == 0, "R5 pc early", pc_out, 0);
      if (n == 40) begin
        check(pc_out == 1, "R5 pc exit", pc_out, 1);
        check(pa_out == 0, "R5 left not early", pa_out, 0);
      end
      if (n == 50) check(pa_out == 1, "R5 left exit", pa_out, 1);
    end
    skip_right = 0;
  endtask

  task automatic t_ignore_R6();
    dir_rev = 0; skip_left = 0; skip_right = 1; do_reset();
    tick(0, 0, 1, 0);
    chk_code(51, 3, "R6 right up entry");
    for (int n = 2; n <= 50; n++) begin
      tick(0, 0, 0, 0);
      if (n == 40) check(pd_out == 0, "R6 pd at 40", pd_out, 0);
      if (n == 50) check(pd_out == 1, "R6 pd at 50", pd_out, 1);
    end
    dir_rev = 1; skip_left = 1; skip_right = 0; do_reset();
    tick(0, 1, 0, 0);
    chk_code(50, 3, "R6 left down entry");
    for (int n = 2; n <= 50; n++) begin
      tick(0, 0, 0, 0);
      if (n == 40) check(pa_out == 0, "R6 pa at 40", pa_out, 0);
      if (n == 50) check(pa_out == 1, "R6 pa at 50", pa_out, 1);
    end
    skip_left = 0;
  endtask

  task automatic t_levels_R7_R8();
    dir_rev = 0; do_reset();
    tick(1, 0, 0, 0);
    for (int f = 0; f < 2; f++) begin
      for (int on = 0; on < 2; on++) begin
        frame_inv = f[0]; disp_on = on[0]; #1;
        if (on == 0) begin
          chk_code(1, 0, "R8 blank sel"); chk_code(2, 0, "R8 blank unsel");
        end else begin
          chk_code(1, f ? 0 : 3, "R7 data1"); chk_code(2, f ? 2 : 1, "R7 data0");
        end
      end
    end
    frame_inv = 0; disp_on = 1;
  endtask

  task automatic t_oe_R9();
    dir_rev = 0; #1;
    check({pa_oe, pb_oe, pc_oe, pd_oe} == 4'b0101, "R9 up oe", {pa_oe, pb_oe, pc_oe, pd_oe}, 5);
    dir_rev = 1; #1;
    check({pa_oe, pb_oe, pc_oe, pd_oe} == 4'b1010, "R9 down oe", {pa_oe, pb_oe, pc_oe, pd_oe}, 10);
  endtask

  initial begin
    @(posedge scan_clk); #1;
    t_reset_R10();
    t_up_R2();
    t_dn_R3();
    t_skip_left_R4();
    t_skip_right_R5();
    t_ignore_R6();
    t_levels_R7_R8();
    t_oe_R9();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule